// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block turns a stream of signed carrier phase-error samples into a frequency estimate. It subtracts an older sample, held a programmable number of samples back, from each new one. The length of that lag sets the discriminator gain. The difference wraps modulo one full turn, so a phase that rolls over from +π to −π does not produce a spurious large frequency.

The frequency term then passes through an offset-and-shift stage, which gives the frequency error used when tracking FSK carriers. Programming zero offset and zero shift makes this stage transparent, which is the setting for PSK. A programmable signed weight scales the error into an AFC correction for the carrier loop. The correction saturates to its output width, and a single enable forces it to zero.

All three results come out of one register stage and share a single valid pulse. That pulse follows each accepted sample once enough history exists for the selected lag.

Top module: `phase_diff_fdisc`

## Requirements
- R1: While reset is asserted, all three outputs are zero and all three valid flags are low.
- R2: For an accepted sample p, `freq_out` = p − h modulo 2^10, read as 10-bit two's complement. Here h is the sample accepted L = `cfg_lag`+1 accepted samples earlier, so `cfg_lag` 0 selects the previous sample and 15 selects the sample 16 back.
- R3: A phase rollover gives the short-way difference. A sample of −500 after 500 at lag 1 yields +24, not −1000.
- R4: The valid flags pulse high for exactly one cycle, on the clock edge after an accepted sample (`smp_vld` high). They do so only if at least L samples were accepted since reset before that sample. At no other time are they high.
- R5: The history advances only on accepted samples. Phase values presented while `smp_vld` is low never enter a difference.
- R6: `ferr_out` (11-bit signed) = (sign-extended `freq_out` + signed 10-bit `cfg_offset`) arithmetically shifted right by `cfg_shift` (0 to 15), rounding toward minus infinity.
- R7: With `cfg_offset` = 0 and `cfg_shift` = 0, `ferr_out` equals `freq_out` sign-extended to 11 bits.
- R8: With `cfg_afc_en` = 1, `afc_out` = `ferr_out` × signed 8-bit `cfg_weight`, saturated to the 16-bit range [−32768, 32767].
- R9: With `cfg_afc_en` = 0, `afc_out` is zero on every valid pulse.
- R10: Between valid pulses, all three outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Phase sample valid strobe |
| smp_phase | input | 10 | Signed phase-error sample, full scale is one turn |
| cfg_lag | input | 4 | Subtraction lag minus one (1 to 16 samples) |
| cfg_offset | input | 10 | Signed offset added to the frequency term |
| cfg_shift | input | 4 | Arithmetic right shift of the offset sum |
| cfg_weight | input | 8 | Signed AFC weight |
| cfg_afc_en | input | 1 | AFC enable; zero forces the correction to zero |
| freq_out | output | 10 | Wrapped phase difference |
| freq_vld | output | 1 | Frequency term valid |
| ferr_out | output | 11 | Frequency error term |
| ferr_vld | output | 1 | Frequency error valid |
| afc_out | output | 16 | Saturated AFC correction |
| afc_vld | output | 1 | AFC correction valid |

## Verification
The assertions that relate outputs to the configuration assume that the configuration seen on the edge that accepts a sample is the one that shaped the result. The bench meets this by driving every input on the falling edge, so each input is steady across the rising edge that samples it. The hold and one-cycle-pulse checks assume nothing about how often samples arrive. The bench therefore randomizes the strobe density, reprograms lag, offset, shift, weight and enable in the middle of the stream, and drives arbitrary phase values while the strobe is low.

// File: rtl/fd_pkg.sv
package fd_pkg;
   localparam int FD_PH_W  = 10;
   localparam int FD_DEPTH = 16;
   localparam int FD_SH_W  = 4;
   localparam int FD_WGT_W = 8;
   localparam int FD_AFC_W = 16;
endpackage

// File: rtl/fd_delay_line.sv
module fd_delay_line #(
   parameter  int W     = 10,
   parameter  int DEPTH = 16,
   localparam int SEL_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [W-1:0]     din,
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     dout,
   output logic             filled
);
   if (DEPTH < 2 || (1 << SEL_W) != DEPTH) begin : g_bad_depth
      $error("fd_delay_line: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]     taps [DEPTH];
   logic [CNT_W-1:0] cnt;

   for (genvar g = 0; g < DEPTH; g++) begin : g_tap
      logic [W-1:0] q;
      logic [W-1:0] d;
      if (g == 0) begin : g_head
         assign d = din;
      end else begin : g_body
         assign d = taps[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (adv) q <= d;
      end
      assign taps[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (adv && cnt != CNT_W'(DEPTH))
         cnt <= cnt + 1'b1;
   end

   assign dout   = taps[sel];
   assign filled = cnt > CNT_W'(sel);
endmodule

// File: rtl/fd_err_shaper.sv
module fd_err_shaper #(
   parameter  int IN_W  = 10,
   parameter  int SH_W  = 4,
   localparam int OUT_W = IN_W + 1
) (
   input  logic [IN_W-1:0]         freq,
   input  logic [IN_W-1:0]         off,
   input  logic [SH_W-1:0]         sh,
   output logic signed [OUT_W-1:0] err
);
   if (IN_W < 2 || SH_W < 1) begin : g_bad_w
      $error("fd_err_shaper: widths too small");
   end

   logic signed [OUT_W-1:0] sum;

   assign sum = $signed({freq[IN_W-1], freq}) + $signed({off[IN_W-1], off});
   assign err = sum >>> sh;
endmodule

// File: rtl/fd_afc_weight.sv
module fd_afc_weight #(
   parameter  int IN_W  = 11,
   parameter  int WGT_W = 8,
   parameter  int OUT_W = 16,
   parameter  bit SAT   = 1'b1,
   localparam int P_W   = IN_W + WGT_W
) (
   input  logic signed [IN_W-1:0]  err,
   input  logic [WGT_W-1:0]        wgt,
   output logic signed [OUT_W-1:0] afc
);
   if (OUT_W > P_W || OUT_W > 62 || OUT_W < 2) begin : g_bad_w
      $error("fd_afc_weight: OUT_W must lie between 2 and the product width");
   end

   logic signed [P_W-1:0] prod;
   assign prod = P_W'(err) * P_W'($signed(wgt));

   if (SAT) begin : g_sat
      localparam logic signed [P_W-1:0] HI = P_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
      localparam logic signed [P_W-1:0] LO = -HI - P_W'(1);
      always_comb begin
         if (prod > HI)      afc = OUT_W'(HI);
         else if (prod < LO) afc = OUT_W'(LO);
         else                afc = prod[OUT_W-1:0];
      end
   end else begin : g_wrap
      assign afc = prod[OUT_W-1:0];
   end
endmodule

// File: rtl/phase_diff_fdisc.sv
module phase_diff_fdisc
   import fd_pkg::*;
#(
   parameter  int PH_W    = FD_PH_W,
   parameter  int DEPTH   = FD_DEPTH,
   parameter  int SH_W    = FD_SH_W,
   parameter  int WGT_W   = FD_WGT_W,
   parameter  int AFC_W   = FD_AFC_W,
   parameter  bit AFC_SAT = 1'b1,
   localparam int LAG_W   = $clog2(DEPTH),
   localparam int ERR_W   = PH_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [PH_W-1:0]  smp_phase,
   input  logic [LAG_W-1:0] cfg_lag,
   input  logic [PH_W-1:0]  cfg_offset,
   input  logic [SH_W-1:0]  cfg_shift,
   input  logic [WGT_W-1:0] cfg_weight,
   input  logic             cfg_afc_en,
   output logic [PH_W-1:0]  freq_out,
   output logic             freq_vld,
   output logic [ERR_W-1:0] ferr_out,
   output logic             ferr_vld,
   output logic [AFC_W-1:0] afc_out,
   output logic             afc_vld
);
   logic [PH_W-1:0]         dly;
   logic                    filled;
   logic [PH_W-1:0]         diff;
   logic signed [ERR_W-1:0] err_c;
   logic signed [AFC_W-1:0] afc_c;
   logic                    out_vld;
   logic                    take;

   fd_delay_line #(.W(PH_W), .DEPTH(DEPTH)) hist_i (
      .clk(clk), .rst_n(rst_n), .adv(smp_vld), .din(smp_phase),
      .sel(cfg_lag), .dout(dly), .filled(filled)
   );

   // modulo-2^PH_W difference: wraps the short way round the circle
   assign diff = smp_phase - dly;
   assign take = smp_vld && filled;

   fd_err_shaper #(.IN_W(PH_W), .SH_W(SH_W)) shp_i (
      .freq(diff), .off(cfg_offset), .sh(cfg_shift), .err(err_c)
   );

   fd_afc_weight #(.IN_W(ERR_W), .WGT_W(WGT_W), .OUT_W(AFC_W), .SAT(AFC_SAT)) wgt_i (
      .err(err_c), .wgt(cfg_weight), .afc(afc_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         freq_out <= '0;
         ferr_out <= '0;
         afc_out  <= '0;
      end else begin
         out_vld <= take;
         if (take) begin
            freq_out <= diff;
            ferr_out <= err_c;
            afc_out  <= cfg_afc_en ? afc_c : '0;
         end
      end
   end

   assign freq_vld = out_vld;
   assign ferr_vld = out_vld;
   assign afc_vld  = out_vld;
endmodule

// File: rtl/fd_chk.sv
module fd_chk #(
   parameter int PH_W  = 10,
   parameter int LAG_W = 4,
   parameter int SH_W  = 4,
   parameter int WGT_W = 8,
   parameter int AFC_W = 16,
   parameter int ERR_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_vld,
   input logic [PH_W-1:0]  cfg_offset,
   input logic [SH_W-1:0]  cfg_shift,
   input logic [WGT_W-1:0] cfg_weight,
   input logic             cfg_afc_en,
   input logic [PH_W-1:0]  freq_out,
   input logic             freq_vld,
   input logic [ERR_W-1:0] ferr_out,
   input logic [AFC_W-1:0] afc_out
);
   // R4
   vld_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_vld |-> $past(smp_vld));

   // R10
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_vld |-> ($stable(freq_out) && $stable(ferr_out) && $stable(afc_out)));

   // R7
   psk_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_vld && $past(cfg_offset) == '0 && $past(cfg_shift) == '0)
      |-> ferr_out == {freq_out[PH_W-1], freq_out});

   // R9
   afc_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_vld && !$past(cfg_afc_en)) |-> afc_out == '0);

   // R8
   zero_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_vld && $past(cfg_weight) == '0) |-> afc_out == '0);
endmodule

bind phase_diff_fdisc fd_chk #(
   .PH_W(PH_W), .LAG_W(LAG_W), .SH_W(SH_W), .WGT_W(WGT_W), .AFC_W(AFC_W), .ERR_W(ERR_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cfg_offset(cfg_offset),
   .cfg_shift(cfg_shift), .cfg_weight(cfg_weight), .cfg_afc_en(cfg_afc_en),
   .freq_out(freq_out), .freq_vld(freq_vld), .ferr_out(ferr_out), .afc_out(afc_out)
);

// File: tb/phase_diff_fdisc_tb.sv
module phase_diff_fdisc_tb_top;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [9:0]  smp_phase = '0;
   logic [3:0]  cfg_lag = '0;
   logic [9:0]  cfg_offset = '0;
   logic [3:0]  cfg_shift = '0;
   logic [7:0]  cfg_weight = 8'd1;
   logic        cfg_afc_en = 1'b1;
   logic [9:0]  freq_out;
   logic        freq_vld;
   logic [10:0] ferr_out;
   logic        ferr_vld;
   logic [15:0] afc_out;
   logic        afc_vld;

   always #5 clk = ~clk;

   phase_diff_fdisc dut_i (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_phase(smp_phase),
      .cfg_lag(cfg_lag), .cfg_offset(cfg_offset), .cfg_shift(cfg_shift),
      .cfg_weight(cfg_weight), .cfg_afc_en(cfg_afc_en),
      .freq_out(freq_out), .freq_vld(freq_vld), .ferr_out(ferr_out),
      .ferr_vld(ferr_vld), .afc_out(afc_out), .afc_vld(afc_vld)
   );

   int checks = 0;
   int fails  = 0;
   bit cmp_on = 1'b0;
   bit done   = 1'b0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // behavioural reference: newest sample at queue front
   int hist[$];
   int e_freq = 0, e_err = 0, e_afc = 0;
   bit e_vld = 1'b0;

   function automatic int wrap10(int d);
      int r;
      r = d & 1023;
      if (r >= 512) r -= 1024;
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      int lag, p, prod;
      if (!rst_n) begin
         hist.delete();
         e_vld = 0; e_freq = 0; e_err = 0; e_afc = 0;
      end else begin
         e_vld = 0;
         if (smp_vld) begin
            lag = int'(cfg_lag) + 1;
            p   = $signed(smp_phase);
            if (hist.size() >= lag) begin
               e_vld  = 1;
               e_freq = wrap10(p - hist[lag-1]);
               e_err  = (e_freq + int'($signed(cfg_offset))) >>> cfg_shift;
               prod   = e_err * int'($signed(cfg_weight));
               if (prod > 32767)  prod = 32767;
               if (prod < -32768) prod = -32768;
               e_afc  = cfg_afc_en ? prod : 0;
            end
            hist.push_front(p);
            if (hist.size() > DEPTH) void'(hist.pop_back());
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R4 freq_vld", int'(freq_vld), int'(e_vld));
         chk("R4 ferr_vld", int'(ferr_vld), int'(e_vld));
         chk("R4 afc_vld",  int'(afc_vld),  int'(e_vld));
         chk(e_vld ? "R2 freq_out" : "R10 freq_out hold", int'($signed(freq_out)), e_freq);
         chk(e_vld ? "R6 ferr_out" : "R10 ferr_out hold", int'($signed(ferr_out)), e_err);
         chk(e_vld ? "R8 afc_out"  : "R10 afc_out hold",  int'($signed(afc_out)),  e_afc);
      end
   end

   task automatic step(bit v, int ph);
      @(negedge clk);
      smp_vld   = v;
      smp_phase = 10'(ph);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk("R1 freq_out reset", int'(freq_out), 0);
      chk("R1 ferr_out reset", int'(ferr_out), 0);
      chk("R1 afc_out reset",  int'(afc_out),  0);
      chk("R1 valid reset",    int'(freq_vld | ferr_vld | afc_vld), 0);
      rst_n  = 1'b1;
      cmp_on = 1'b1;

      // R4 fill: lag 4 needs four stored samples
      cfg_lag = 4'd3;
      step(1, 10); step(1, 20); step(1, 40); step(1, 80);
      step(0, 0);
      chk("R4 not yet filled", int'(freq_vld), 0);
      step(1, 160); step(0, 0);
      chk("R4 first valid", int'(freq_vld), 1);
      chk("R2 lag4 diff", int'($signed(freq_out)), 150);

      // R5 idle phases are ignored
      cfg_lag = 4'd0;
      step(1, 100);
      for (int i = 0; i < 5; i++) step(0, 300 + i);
      step(1, 130); step(0, 0);
      chk("R5 gap ignored", int'($signed(freq_out)), 30);

      // R3 wrap, R7 passthrough
      step(1, 500); step(1, -500); step(0, 0);
      chk("R3 wrap diff", int'($signed(freq_out)), 24);
      chk("R7 passthrough", int'($signed(ferr_out)), 24);

      // R9 AFC disabled
      cfg_afc_en = 1'b0; cfg_weight = 8'd5;
      step(1, 12); step(0, 0);
      chk("R3 half-turn", int'($signed(freq_out)), -512);
      chk("R9 afc off", int'($signed(afc_out)), 0);

      // R8 saturation
      cfg_afc_en = 1'b1; cfg_weight = 8'd127; cfg_offset = 10'd200;
      step(1, 500); step(0, 0);
      chk("R8 sat high", int'($signed(afc_out)), 32767);
      cfg_weight = 8'h80;
      step(1, 600 - 1024); step(0, 0);
      chk("R8 sat low", int'($signed(afc_out)), -32768);

      // R6 shift with floor rounding
      cfg_offset = 10'(-7); cfg_shift = 4'd3; cfg_weight = 8'd1;
      step(1, 9); step(1, 100); step(0, 0);
      chk("R6 pos shift", int'($signed(ferr_out)), 10);
      step(1, 0); step(0, 0);
      chk("R6 neg shift", int'($signed(ferr_out)), -14);

      // random stream with reprogramming
      for (int n = 0; n < 3000; n++) begin
         if (n % 250 == 0) begin
            cfg_lag    = 4'($urandom);
            cfg_offset = (n % 500 == 0) ? 10'd0 : 10'($urandom);
            cfg_shift  = (n % 500 == 0) ? 4'd0  : 4'($urandom);
            cfg_weight = 8'($urandom);
            cfg_afc_en = 1'($urandom);
         end
         step(1'($urandom), int'($urandom % 1024));
      end
      step(0, 0);
      step(0, 0);
      summary();
   end
endmodule